// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the software-facing front end of an interrupt routing unit. It appears on a simple 32-bit bus as two locations: a select register and a data window. Software writes an index into the select register and then reads or writes the data window. That reaches one of several internal registers:

- an identification field;
- a fixed version word;
- an arbitration word that always reads as zero;
- a table of 64-bit per-pin routing entries, each reached as two 32-bit halves.

The block holds the select register, the identification field and the routing table. It presents every entry in parallel to the delivery logic, which is a separate block. After each write to a table half it raises a one-cycle service request, so the delivery logic can re-evaluate pending inputs against the new settings.

Writes take effect on the clock edge at which `bus_wr` is high. Read data is combinational from the current state while `bus_rd` is high.

Top module: `intr_regwin`

## Requirements
- R1: Only `bus_addr` (the low address byte) is decoded. A write to offset 0x00 loads `bus_wdata[7:0]` into the select register. A read of offset 0x00 returns the select value in bits 7:0, with all other bits zero.
- R2: With select 0x00, a window (offset 0x10) read returns the 4-bit ID in bits 27:24 and zero elsewhere. A window write stores `bus_wdata[27:24]` as the ID, and `cur_id` shows it.
- R3: With select 0x01, a window read returns 0x11 in bits 7:0 and NPINS-1 in bits 23:16. Window writes with this select change nothing.
- R4: With select 0x02, window reads return 0 and window writes change nothing.
- R5: Select 0x10+2n reaches bits 31:0 of entry n, and select 0x11+2n reaches bits 63:32. A write replaces only the addressed half. Entry n appears on `ent_flat[64n+63:64n]`.
- R6: Selects from 0x03 to 0x0F, and selects at or beyond 0x10+2*NPINS, read as 0 through the window. Writes with these selects change nothing and raise no service request.
- R7: During reset and after it, the select register and the ID are 0. Every entry is 0x0000_0000_0001_0000, meaning only bit 16 (the mask bit) is set.
- R8: `svc_req` is high for exactly the one cycle after each edge that wrote a valid table half, and is low at all other times.
- R9: Reads of any offset other than 0x00 and 0x10 return 0. Writes to such offsets change nothing.
- R10: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Low address byte of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ent_flat | output | NPINS*64 | All routing entries, entry n in bits 64n+63:64n |
| cur_id | output | 4 | Current ID field |
| svc_req | output | 1 | One-cycle service request after a table write |

## Verification
A wrong select value shows up on the very next window access: the data lands in, or is read from, a different register or entry half. A corrupted entry is visible on `ent_flat` in the cycle after the edge that wrote it. A missing or doubled service request is visible on `svc_req` one cycle after the write. The reference model compares the full entry vector and `svc_req` at every step, so a wrong write strobe or a write that touches the wrong half is caught within one cycle, even before software reads it back.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam logic [7:0]  OFS_SEL      = 8'h00;
    localparam logic [7:0]  OFS_WIN      = 8'h10;
    localparam logic [7:0]  IDX_TBL_BASE = 8'h10;
    localparam logic [7:0]  VERSION_VAL  = 8'h11;
    localparam int          MASK_POS     = 16;
    localparam logic [63:0] ENT_RST      = 64'(1) << MASK_POS;

    typedef enum logic [2:0] {
        SEL_ID,
        SEL_VER,
        SEL_ARB,
        SEL_TBL,
        SEL_NONE
    } win_kind_e;

    typedef struct packed {
        logic [7:0] sel;
        logic [3:0] id;
        logic       svc;
    } regs_t;
endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic [7:0] bus_addr,
    input  logic [7:0] sel_q,
    output logic       hit_sel,
    output logic       hit_win,
    output win_kind_e  kind,
    output logic [6:0] tbl_idx,
    output logic       tbl_hi
);
    logic [7:0] rel;

    always_comb begin
        hit_sel = (bus_addr == OFS_SEL);
        hit_win = (bus_addr == OFS_WIN);
        rel     = sel_q - IDX_TBL_BASE;
        tbl_idx = rel[7:1];
        tbl_hi  = rel[0];
        if (sel_q == 8'h00)
            kind = SEL_ID;
        else if (sel_q == 8'h01)
            kind = SEL_VER;
        else if (sel_q == 8'h02)
            kind = SEL_ARB;
        else if (sel_q >= IDX_TBL_BASE && 32'(rel[7:1]) < NPINS)
            kind = SEL_TBL;
        else
            kind = SEL_NONE;
    end
endmodule

// File: rtl/irw_table.sv
module irw_table
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IW = $clog2(NPINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [IW-1:0]       wr_idx,
    input  logic [31:0]         wdata,
    input  logic [IW-1:0]       rd_idx,
    input  logic                rd_hi,
    output logic [31:0]         rd_data,
    output logic [NPINS*64-1:0] ent_flat
);
    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        logic [63:0] ent_d;
        logic [63:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_idx == IW'(g)) begin
                if (wr_lo) ent_d[31:0]  = wdata;
                if (wr_hi) ent_d[63:32] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= ENT_RST;
            else        ent_q <= ent_d;
        end

        assign ent_flat[g*64 +: 64] = ent_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (rd_idx == IW'(i))
                rd_data = rd_hi ? ent_flat[i*64+32 +: 32] : ent_flat[i*64 +: 32];
        end
    end

    // R5: a single access never reaches both halves
    a_r5_one_half: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo && wr_hi));
endmodule

// File: rtl/intr_regwin.sv
module intr_regwin
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IW = $clog2(NPINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NPINS*64-1:0] ent_flat,
    output logic [3:0]          cur_id,
    output logic                svc_req
);
    regs_t      r_d, r_q;
    logic       hit_sel, hit_win, tbl_hi, wr_tbl;
    win_kind_e  kind;
    logic [6:0] tbl_idx;
    logic [31:0] tbl_rd;

    irw_decode #(.NPINS(NPINS)) u_dec (
        .bus_addr (bus_addr),
        .sel_q    (r_q.sel),
        .hit_sel  (hit_sel),
        .hit_win  (hit_win),
        .kind     (kind),
        .tbl_idx  (tbl_idx),
        .tbl_hi   (tbl_hi)
    );

    assign wr_tbl = bus_wr && hit_win && (kind == SEL_TBL);

    irw_table #(.NPINS(NPINS)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_tbl && !tbl_hi),
        .wr_hi    (wr_tbl && tbl_hi),
        .wr_idx   (tbl_idx[IW-1:0]),
        .wdata    (bus_wdata),
        .rd_idx   (tbl_idx[IW-1:0]),
        .rd_hi    (tbl_hi),
        .rd_data  (tbl_rd),
        .ent_flat (ent_flat)
    );

    always_comb begin
        r_d     = r_q;
        r_d.svc = wr_tbl;
        if (bus_wr && hit_sel)
            r_d.sel = bus_wdata[7:0];
        if (bus_wr && hit_win && kind == SEL_ID)
            r_d.id = bus_wdata[27:24];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_sel) begin
                bus_rdata = {24'h0, r_q.sel};
            end else if (hit_win) begin
                case (kind)
                    SEL_ID:  bus_rdata = {4'h0, r_q.id, 24'h0};
                    SEL_VER: bus_rdata = {8'h00, 8'(NPINS - 1), 8'h00, VERSION_VAL};
                    SEL_TBL: bus_rdata = tbl_rd;
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assign cur_id  = r_q.id;
    assign svc_req = r_q.svc;

    // R8: a service request always follows a bus write
    a_r8_svc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> $past(bus_wr));
    // R1: select register only moves on a write
    a_r1_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(r_q.sel));
    // R2: ID only moves on a write
    a_r2_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cur_id));
    // R5: table only moves on a write
    a_r5_tbl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(ent_flat));
    // R10: idle bus reads zero
    a_r10_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 32'h0));
endmodule

// File: tb/intr_regwin_tb.sv
module intr_regwin_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS = 24;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [7:0]          bus_addr = '0;
    logic                bus_wr = 1'b0;
    logic                bus_rd = 1'b0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NPINS*64-1:0] ent_flat;
    logic [3:0]          cur_id;
    logic                svc_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [63:0] m_tbl [NPINS];
    int          m_sel;
    int          m_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_regwin #(.NPINS(NPINS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_flat(ent_flat), .cur_id(cur_id), .svc_req(svc_req)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int addr);
        int t;
        if (addr == 0) return 32'(m_sel);
        if (addr != 16) return 0;
        if (m_sel == 0) return 32'(m_id) << 24;
        if (m_sel == 1) return 32'h11 | (32'(NPINS - 1) << 16);
        if (m_sel < 16) return 0;
        t = m_sel - 16;
        if (t / 2 >= NPINS) return 0;
        return (t % 2 == 1) ? m_tbl[t/2][63:32] : m_tbl[t/2][31:0];
    endfunction

    task automatic check_table(string req);
        for (int i = 0; i < NPINS; i++)
            chk(req, ent_flat[i*64 +: 64], m_tbl[i]);
    endtask

    // one write cycle; checks svc_req and entries afterwards (starts at negedge)
    task automatic wr(int addr, logic [31:0] data, string req);
        int  t;
        bit  svc_exp;
        svc_exp = 0;
        bus_addr = 8'(addr); bus_wdata = data; bus_wr = 1'b1;
        @(posedge clk);
        if (addr == 0) m_sel = int'(data[7:0]);
        else if (addr == 16) begin
            if (m_sel == 0) m_id = int'(data[27:24]);
            else if (m_sel >= 16) begin
                t = m_sel - 16;
                if (t / 2 < NPINS) begin
                    svc_exp = 1;
                    if (t % 2 == 1) m_tbl[t/2][63:32] = data;
                    else            m_tbl[t/2][31:0]  = data;
                end
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        chk({req, " svc"}, 64'(svc_req), 64'(svc_exp));
        chk({req, " id"}, 64'(cur_id), 64'(m_id));
        check_table(req);
    endtask

    task automatic idle(string req);
        @(posedge clk);
        @(negedge clk);
        chk({req, " svc idle"}, 64'(svc_req), 64'h0);
        check_table(req);
    endtask

    task automatic rd(int addr, string req);
        bus_addr = 8'(addr); bus_rd = 1'b1;
        #1;
        chk(req, 64'(bus_rdata), 64'(model_read(addr)));
        bus_rd = 1'b0;
        #1;
        chk("R10", 64'(bus_rdata), 64'h0);
        idle(req);
    endtask

    initial begin
        for (int i = 0; i < NPINS; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
        m_sel = 0; m_id = 0;
        repeat (3) @(negedge clk);
        check_table("R7 reset");
        chk("R7 svc", 64'(svc_req), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, "R7 sel");
        rd(16, "R7 id");
        // R2 ID
        wr(16, 32'hFAB0_1234, "R2");
        rd(16, "R2 read");
        // R1 select
        wr(0, 32'hFFFF_FF01, "R1");
        rd(0, "R1 read");
        // R3 version
        rd(16, "R3 read");
        wr(16, 32'hFFFF_FFFF, "R3 write");
        rd(16, "R3 reread");
        // R4 arbitration
        wr(0, 2, "R1");
        rd(16, "R4 read");
        wr(16, 32'hFFFF_FFFF, "R4 write");
        rd(16, "R4 reread");
        rd(0, "R1 sel2");
        // R5 table halves
        wr(0, 32'h10, "R1");
        wr(16, 32'h0000_0031, "R5 lo0");
        idle("R8");
        wr(0, 32'h11, "R1");
        wr(16, 32'hFF00_0000, "R5 hi0");
        rd(16, "R5 hi0 read");
        wr(0, 32'h10, "R1");
        rd(16, "R5 lo0 read");
        wr(0, 32'h3E, "R1");
        wr(16, 32'hDEAD_BEEF, "R5 lo last");
        wr(16, 32'h1234_5678, "R8 back-to-back");
        rd(16, "R5 lo last read");
        wr(0, 32'h3F, "R1");
        wr(16, 32'hCAFE_0001, "R5 hi last");
        rd(16, "R5 hi last read");
        wr(0, 32'h17, "R1");
        wr(16, 32'h0000_0099, "R5 hi3");
        rd(16, "R5 hi3 read");
        // R6 out of range
        wr(0, 32'h40, "R1");
        wr(16, 32'hFFFF_FFFF, "R6 past end");
        rd(16, "R6 past end read");
        wr(0, 32'h05, "R1");
        wr(16, 32'hFFFF_FFFF, "R6 gap");
        rd(16, "R6 gap read");
        wr(0, 32'hFF, "R1");
        wr(16, 32'hFFFF_FFFF, "R6 top");
        rd(16, "R6 top read");
        // R9 unmapped offsets
        wr(4, 32'hFFFF_FFFF, "R9 write 04");
        wr(32, 32'h0000_0000, "R9 write 20");
        rd(4, "R9 read 04");
        rd(32, "R9 read 20");
        rd(0, "R9 sel kept");
        // R10 idle read port with a live select
        bus_addr = 8'h00;
        #1;
        chk("R10 idle", 64'(bus_rdata), 64'h0);
        idle("R8");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule